// File: doc/BRIEF.md
# Paged Bus Address Decoder with Peripheral Expansion Window

This block sits on the bus of an 8-bit processor with a 16-bit address space. For every access it looks at the high address byte and routes the access to one of several regions: main RAM, system ROM, the base ROM page of a peripheral slot, or a shared 2 KB expansion window. It returns the read byte of the region it chose. A read from an address that no region claims returns a fixed filler byte. A write that no region claims is dropped.

The shared window at pages 0xC8–0xCF is stateful. Any access to a slot's base page (0xC1–0xC7) makes that slot the active slot. If that slot has an expansion ROM, the window is routed to it for reads. An access to address 0xCFFF makes the active slot 0 and unmaps the window, unless the internal-ROM override input is high. Both state updates take effect before the page lookup of the same access. All outputs are registered and appear one clock after the strobe.

Top module: `pdec_top`

## Requirements
- R1: After reset, activeSlot is 0, regionSel is NONE (code 0), rdData is 0xF4, and the expansion window is unmapped.
- R2: An access with high byte 0x00–0xBF is routed to RAM (code 1). A read returns ramRdData. A write raises ramWe for one cycle. When busRd and busWr are both high, the access is a read.
- R3: A read with high byte 0xD0–0xFF is routed to ROM (code 2) and returns romRdData. A write there yields NONE and leaves ramWe low.
- R4: Any read or write with high byte 0xC1–0xC7 loads address bits [10:8] into activeSlot. A read is routed to the slot's base ROM (code 3), returns slotRdData[slot], and drives selSlot with the slot number.
- R5: When a slot whose extPresent bit is set becomes active, a later read of pages 0xC8–0xCF is routed to the window (code 4). It returns expRdData of that slot and drives selSlot with the owning slot.
- R6: When a slot whose extPresent bit is clear becomes active, activeSlot is updated but the window keeps its earlier mapping, which may be mapped to another slot or unmapped.
- R7: A read or write of address 0xCFFF with intRomOvr low clears activeSlot to 0 and unmaps the window before that access's own lookup, so a read there returns NONE and 0xF4.
- R8: While intRomOvr is high, an access to 0xCFFF leaves activeSlot and the window mapping unchanged, and a read there is served by the window.
- R9: A read of page 0xC0, or of the window while it is unmapped, returns NONE and 0xF4. Writes to pages 0xC0–0xCF never raise ramWe.
- R10: In a cycle with neither strobe high, activeSlot and the window mapping hold their values and the registered outputs show NONE and 0xF4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 16 | Access address |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| intRomOvr | input | 1 | Internal-ROM override; when high it blocks the 0xCFFF release |
| extPresent | input | 8 | One bit per slot, set when that slot has an expansion ROM |
| ramRdData | input | 8 | Read data from main RAM |
| romRdData | input | 8 | Read data from system ROM |
| slotRdData | input | 8x8 | Base-ROM read data for each slot (packed by slot) |
| expRdData | input | 8x8 | Expansion-ROM read data for each slot (packed by slot) |
| regionSel | output | 3 | Registered region code: 0 NONE, 1 RAM, 2 ROM, 3 SLOT, 4 EXP |
| rdData | output | 8 | Registered read byte |
| ramWe | output | 1 | Registered RAM write enable |
| selSlot | output | 3 | Slot whose ROM served the last SLOT or EXP read |
| activeSlot | output | 3 | Current active slot |

## Verification
The hardest state to reach is a window that stays routed to one slot while a different slot is active. The stimulus reaches it by touching a slot that has an expansion ROM and then a slot that has none, and then reads the window. The override case is also hard to reach. There the window must already be mapped when 0xCFFF is read, and a read served by the window proves that the release was suppressed. Idle cycles place 0xCFFF on the address with no strobe, which shows that the release depends on the strobe.

// File: rtl/pdec_pkg.sv
package pdec_pkg;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 8;
  localparam int NUM_SLOTS = 8;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);

  localparam logic [7:0] RAM_LAST_PG  = 8'hBF;
  localparam logic [7:0] IO_PG        = 8'hC0;
  localparam logic [7:0] SLOT_FIRST   = 8'hC1;
  localparam logic [7:0] SLOT_LAST    = 8'hC7;
  localparam logic [7:0] WIN_FIRST    = 8'hC8;
  localparam logic [7:0] WIN_LAST     = 8'hCF;
  localparam logic [7:0] ROM_FIRST_PG = 8'hD0;
  localparam logic [ADDR_W-1:0] RELEASE_ADDR = 16'hCFFF;
  localparam logic [DATA_W-1:0] FILLER      = 8'hF4;

  typedef enum logic [2:0] {
    RG_NONE = 3'd0,
    RG_RAM  = 3'd1,
    RG_ROM  = 3'd2,
    RG_SLOT = 3'd3,
    RG_EXP  = 3'd4
  } region_e;

  typedef struct packed {
    logic              accRd;
    logic              accWr;
    logic              winMapped;
    logic [SLOT_W-1:0] winOwner;
  } ctrl_t;
endpackage

// File: rtl/pdec_ctrl.sv
module pdec_ctrl
  import pdec_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    accAddr,
  input  logic                 busRd,
  input  logic                 busWr,
  input  logic                 intRomOvr,
  input  logic [NUM_SLOTS-1:0] extPresent,
  output ctrl_t                ctrlOut,
  output logic [SLOT_W-1:0]    activeSlot
);
  logic [7:0]        hiByte;
  logic              accValid, isRelease, isSlotHit;
  logic [SLOT_W-1:0] hitSlot, slotNxt, ownNxt, winOwner;
  logic              mapNxt, winMapped;

  assign hiByte    = accAddr[ADDR_W-1 -: 8];
  assign accValid  = busRd | busWr;
  assign isRelease = accValid && (accAddr == RELEASE_ADDR) && !intRomOvr;
  assign isSlotHit = accValid && (hiByte >= SLOT_FIRST) && (hiByte <= SLOT_LAST);
  assign hitSlot   = hiByte[SLOT_W-1:0];

  // Release first, then slot capture; the lookup sees the result.
  always_comb begin
    slotNxt = activeSlot;
    mapNxt  = winMapped;
    ownNxt  = winOwner;
    if (isRelease) begin
      slotNxt = '0;
      mapNxt  = 1'b0;
    end
    if (isSlotHit && (hitSlot != slotNxt)) begin
      slotNxt = hitSlot;
      if (extPresent[hitSlot]) begin
        mapNxt = 1'b1;
        ownNxt = hitSlot;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeSlot <= '0;
      winMapped  <= 1'b0;
      winOwner   <= '0;
    end else begin
      activeSlot <= slotNxt;
      winMapped  <= mapNxt;
      winOwner   <= ownNxt;
    end
  end

  assign ctrlOut = '{accRd: busRd, accWr: busWr & ~busRd,
                     winMapped: mapNxt, winOwner: ownNxt};

  p_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accAddr == RELEASE_ADDR && !intRomOvr) |=> (activeSlot == '0 && !winMapped));
  p_override_r8: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accAddr == RELEASE_ADDR && intRomOvr) |=> ($stable(activeSlot) && $stable(winMapped)));
  p_slot_capture_r4: assert property (@(posedge clk) disable iff (!rstN)
    isSlotHit |=> (activeSlot == $past(hitSlot)));
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> ($stable(activeSlot) && $stable(winMapped) && $stable(winOwner)));
endmodule

// File: rtl/pdec_dpath.sv
module pdec_dpath
  import pdec_pkg::*;
(
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [7:0]                         hiByte,
  input  ctrl_t                              ctrlIn,
  input  logic [DATA_W-1:0]                  ramRdData,
  input  logic [DATA_W-1:0]                  romRdData,
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0]   slotRdData,
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0]   expRdData,
  output logic [2:0]                         regionSel,
  output logic [DATA_W-1:0]                  rdData,
  output logic                               ramWe,
  output logic [SLOT_W-1:0]                  selSlot
);
  region_e           regNxt;
  logic [DATA_W-1:0] dataNxt;
  logic              weNxt;
  logic [SLOT_W-1:0] slotSelNxt, pageSlot;

  assign pageSlot = hiByte[SLOT_W-1:0];

  always_comb begin
    regNxt     = RG_NONE;
    dataNxt    = FILLER;
    weNxt      = 1'b0;
    slotSelNxt = selSlot;
    if (hiByte <= RAM_LAST_PG) begin
      if (ctrlIn.accRd) begin
        regNxt  = RG_RAM;
        dataNxt = ramRdData;
      end else if (ctrlIn.accWr) begin
        regNxt = RG_RAM;
        weNxt  = 1'b1;
      end
    end else if (hiByte >= ROM_FIRST_PG) begin
      if (ctrlIn.accRd) begin
        regNxt  = RG_ROM;
        dataNxt = romRdData;
      end
    end else if (hiByte >= SLOT_FIRST && hiByte <= SLOT_LAST) begin
      if (ctrlIn.accRd) begin
        regNxt     = RG_SLOT;
        dataNxt    = slotRdData[pageSlot];
        slotSelNxt = pageSlot;
      end
    end else if (hiByte >= WIN_FIRST && hiByte <= WIN_LAST) begin
      if (ctrlIn.accRd && ctrlIn.winMapped) begin
        regNxt     = RG_EXP;
        dataNxt    = expRdData[ctrlIn.winOwner];
        slotSelNxt = ctrlIn.winOwner;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regionSel <= RG_NONE;
      rdData    <= FILLER;
      ramWe     <= 1'b0;
      selSlot   <= '0;
    end else begin
      regionSel <= regNxt;
      rdData    <= dataNxt;
      ramWe     <= weNxt;
      selSlot   <= slotSelNxt;
    end
  end

  p_rom_no_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regionSel == RG_ROM) |-> !ramWe);
  p_filler_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regionSel == RG_NONE) |-> (rdData == FILLER && !ramWe));
  p_exp_needs_map_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regionSel == RG_EXP) |-> $past(ctrlIn.winMapped));
  p_we_only_ram_r2: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (regionSel == RG_RAM));
endmodule

// File: rtl/pdec_top.sv
module pdec_top
  import pdec_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [15:0]                      busAddr,
  input  logic                             busRd,
  input  logic                             busWr,
  input  logic                             intRomOvr,
  input  logic [7:0]                       extPresent,
  input  logic [7:0]                       ramRdData,
  input  logic [7:0]                       romRdData,
  input  logic [7:0][7:0]                  slotRdData,
  input  logic [7:0][7:0]                  expRdData,
  output logic [2:0]                       regionSel,
  output logic [7:0]                       rdData,
  output logic                             ramWe,
  output logic [2:0]                       selSlot,
  output logic [2:0]                       activeSlot
);
  ctrl_t ctrlBus;

  pdec_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .accAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .intRomOvr(intRomOvr), .extPresent(extPresent),
    .ctrlOut(ctrlBus), .activeSlot(activeSlot)
  );

  pdec_dpath u_dpath (
    .clk(clk), .rstN(rstN), .hiByte(busAddr[15:8]), .ctrlIn(ctrlBus),
    .ramRdData(ramRdData), .romRdData(romRdData),
    .slotRdData(slotRdData), .expRdData(expRdData),
    .regionSel(regionSel), .rdData(rdData), .ramWe(ramWe), .selSlot(selSlot)
  );
endmodule

// File: tb/pdec_top_test.sv
module pdec_top_test;
  logic clk = 1'b0, rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic busRd = 1'b0, busWr = 1'b0, intRomOvr = 1'b0;
  logic [7:0] extPresent = 8'b0010_0100;
  logic [7:0] ramRdData = 8'h5A, romRdData = 8'hA5;
  logic [7:0][7:0] slotRdData, expRdData;
  logic [2:0] regionSel, selSlot, activeSlot;
  logic [7:0] rdData;
  logic ramWe;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pdec_top uut (.*);

  initial begin
    for (int s = 0; s < 8; s++) begin
      slotRdData[s] = 8'h10 + 8'(s);
      expRdData[s]  = 8'h80 + 8'(s);
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic acc(logic [15:0] a, logic rd, logic wr);
    @(negedge clk);
    busAddr = a; busRd = rd; busWr = wr;
    @(posedge clk);
    #1;
    busRd = 1'b0; busWr = 1'b0;
  endtask

  task automatic expect3(string tag, int rg, int dat, int slot);
    chk({tag, " region"}, int'(regionSel), rg);
    chk({tag, " data"}, int'(rdData), dat);
    chk({tag, " activeSlot"}, int'(activeSlot), slot);
  endtask

  task automatic t_reset;
    chk("R1 reset region", int'(regionSel), 0);
    chk("R1 reset data", int'(rdData), 8'hF4);
    chk("R1 reset slot", int'(activeSlot), 0);
    acc(16'hC800, 1, 0);
    expect3("R1 window unmapped", 0, 8'hF4, 0);
  endtask

  task automatic t_ram;
    acc(16'h1234, 1, 0);
    expect3("R2 ram read", 1, 8'h5A, 0);
    chk("R2 ram read we", int'(ramWe), 0);
    acc(16'hBFFF, 0, 1);
    chk("R2 ram write region", int'(regionSel), 1);
    chk("R2 ram write we", int'(ramWe), 1);
    acc(16'h0000, 1, 1);
    chk("R2 both strobes is read", int'(ramWe), 0);
    chk("R2 both strobes data", int'(rdData), 8'h5A);
  endtask

  task automatic t_rom;
    acc(16'hD000, 1, 0);
    expect3("R3 rom read", 2, 8'hA5, 0);
    acc(16'hFFFF, 0, 1);
    chk("R3 rom write region", int'(regionSel), 0);
    chk("R3 rom write we", int'(ramWe), 0);
  endtask

  task automatic t_unmapped;
    acc(16'hC000, 1, 0);
    expect3("R9 io page read", 0, 8'hF4, 0);
    acc(16'hC050, 0, 1);
    chk("R9 io write we", int'(ramWe), 0);
  endtask

  task automatic t_slot_present;
    acc(16'hC200, 1, 0);
    expect3("R4 slot2 base", 3, 8'h12, 2);
    chk("R4 selSlot", int'(selSlot), 2);
    acc(16'hC800, 1, 0);
    expect3("R5 window slot2", 4, 8'h82, 2);
    chk("R5 window selSlot", int'(selSlot), 2);
    acc(16'hC9AB, 0, 1);
    chk("R9 window write we", int'(ramWe), 0);
  endtask

  task automatic t_slot_absent;
    acc(16'hC300, 0, 1);
    chk("R4 write captures slot", int'(activeSlot), 3);
    chk("R4 slot write region", int'(regionSel), 0);
    acc(16'hCA00, 1, 0);
    expect3("R6 window keeps slot2", 4, 8'h82, 3);
  endtask

  task automatic t_release;
    acc(16'hCFFF, 1, 0);
    expect3("R7 release read", 0, 8'hF4, 0);
    acc(16'hC800, 1, 0);
    expect3("R7 window unmapped", 0, 8'hF4, 0);
    acc(16'hC300, 1, 0);
    acc(16'hC800, 1, 0);
    expect3("R6 absent keeps unmapped", 0, 8'hF4, 3);
  endtask

  task automatic t_override;
    acc(16'hC500, 1, 0);
    expect3("R4 slot5 base", 3, 8'h15, 5);
    @(negedge clk); intRomOvr = 1'b1;
    acc(16'hCFFF, 1, 0);
    expect3("R8 override keeps window", 4, 8'h85, 5);
    @(negedge clk); intRomOvr = 1'b0;
    acc(16'hCFFF, 0, 1);
    chk("R7 write release slot", int'(activeSlot), 0);
    acc(16'hC900, 1, 0);
    expect3("R7 after write release", 0, 8'hF4, 0);
  endtask

  task automatic t_idle;
    acc(16'hC200, 1, 0);
    @(negedge clk);
    busAddr = 16'hCFFF;
    @(posedge clk); #1;
    expect3("R10 idle", 0, 8'hF4, 2);
    acc(16'hC800, 1, 0);
    expect3("R10 window held", 4, 8'h82, 2);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    t_reset;
    t_ram;
    t_rom;
    t_unmapped;
    t_slot_present;
    t_slot_absent;
    t_release;
    t_override;
    t_idle;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule